// File: doc/BRIEF.md
# Key-Gated Download Request Control

This block holds the small control registers through which software asks for a built-in programming routine to be copied into on-chip RAM. Software first writes an unlock byte into a key register. It may then pick the programming routine through a select bit. Last, it writes a 1 to the request bit. The request only takes effect if three things are true at the moment of that write: the key matches, the CPU is fetching from on-chip RAM, and RAM emulation mode is off. If any of them fails, the write is dropped without any sign.

An accepted request sends a one-cycle start pulse to the transfer engine. It also raises a busy flag, which stays up until the engine returns its done strobe. The done strobe lowers busy and clears the routine-select bit. The request bit always reads as 0, so software cannot see it set; the busy flag is the only outward sign that a download is running.

A simple register bus reaches the three registers. It has an address, a write enable, write data and combinational read data.

Top module: `dlreq_ctrl`

## Requirements
- R1: The key register resets to 0x00, takes the full write byte when written at address 0, and reads that byte back at address 0.
- R2: Writing a byte with bit 0 set to address 1 is accepted when the key holds 0xA5, `cpu_in_ram` is 1, `ram_emul_on` is 0 and `dl_busy` is 0. After the accepting clock edge, `dl_start` is 1 for exactly one cycle and `dl_busy` becomes 1.
- R3: A request write while the key holds any value other than 0xA5 gives no start pulse and leaves `dl_busy` at 0.
- R4: A request write while `cpu_in_ram` is 0 gives no start pulse and leaves `dl_busy` at 0.
- R5: A request write while `ram_emul_on` is 1 gives no start pulse and leaves `dl_busy` at 0.
- R6: `xfer_done` sampled while busy brings `dl_busy` to 0 after that edge. A request write made while busy is ignored, and this includes a write in the same cycle as `xfer_done`.
- R7: Address 1 always reads 0x00, including while a download is in progress.
- R8: A write to address 2 stores bit 0 of the write data in `prog_sel`. Address 2 reads `prog_sel` in bit 0, and bits 7 to 1 always read 0 whatever was written to them.
- R9: `xfer_done` clears `prog_sel`. When a write to address 2 falls in the same cycle as `xfer_done`, the clear wins.
- R10: After reset, `dl_start`, `dl_busy` and `prog_sel` are 0 and every address reads 0x00. A write to address 1 with bit 0 clear starts nothing.
- R11: Any address other than 0, 1 and 2 reads 0x00, and writes to such an address change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Combinational read data for `bus_addr` |
| cpu_in_ram | input | 1 | CPU is executing from on-chip RAM |
| ram_emul_on | input | 1 | RAM emulation mode is active |
| xfer_done | input | 1 | Transfer engine reports the download complete |
| dl_start | output | 1 | One-cycle download start pulse |
| dl_busy | output | 1 | Download in progress |
| prog_sel | output | 1 | Programming routine selected |

## Verification
Two events can arrive in the same cycle, and both cases are driven on purpose. In the first, the done strobe lands in the same cycle as a fresh valid request write: busy must drop, and no new start pulse may follow. In the second, the done strobe coincides with a write of 1 to the routine-select register: the select bit must read 0 afterwards. The bench drives each of these pairs in one cycle. It then compares start, busy, select and the read data on every clock against a behavioural model, which settles the ordering as clear-before-accept and clear-over-write.

// File: rtl/dlreq_pkg.sv
package dlreq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KEY  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_PSEL = 2'd3
   } dl_sel_e;

   localparam int unsigned REQ_BIT = 0;
   localparam int unsigned PSEL_BIT = 0;

endpackage

// File: rtl/dlreq_decode.sv
module dlreq_decode
   import dlreq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned KEY_ADDR  = 0,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned PSEL_ADDR = 2
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   output dl_sel_e           sel,
   output logic              wr_key,
   output logic              wr_ctrl,
   output logic              wr_psel
);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_PSEL = ADDR_W'(PSEL_ADDR);

   always_comb begin
      if (bus_addr == A_KEY)       sel = SEL_KEY;
      else if (bus_addr == A_CTRL) sel = SEL_CTRL;
      else if (bus_addr == A_PSEL) sel = SEL_PSEL;
      else                         sel = SEL_NONE;
   end

   assign wr_key  = bus_we && (sel == SEL_KEY);
   assign wr_ctrl = bus_we && (sel == SEL_CTRL);
   assign wr_psel = bus_we && (sel == SEL_PSEL);
endmodule

// File: rtl/dlreq_gate.sv
module dlreq_gate #(
   parameter int unsigned DATA_W     = 8,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_key,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_ctrl,
   input  logic              req_bit,
   input  logic              cpu_in_ram,
   input  logic              ram_emul_on,
   input  logic              busy,
   output logic [DATA_W-1:0] key_q,
   output logic              accept
);
   logic key_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)      key_q <= '0;
      else if (wr_key) key_q <= wdata;
   end

   assign key_ok = (key_q == UNLOCK_KEY);
   // all three conditions are judged at the write itself
   assign accept = wr_ctrl && req_bit && key_ok && cpu_in_ram && !ram_emul_on && !busy;
endmodule

// File: rtl/dlreq_seq.sv
module dlreq_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic xfer_done,
   input  logic wr_psel,
   input  logic psel_bit,
   output logic dl_start,
   output logic dl_busy,
   output logic prog_sel
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dl_start <= 1'b0;
         dl_busy  <= 1'b0;
      end else begin
         dl_start <= accept;
         // accept needs !dl_busy, so it never meets a clear of the same flag
         dl_busy  <= accept | (dl_busy & ~xfer_done);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         prog_sel <= 1'b0;
      else if (xfer_done) prog_sel <= 1'b0;
      else if (wr_psel)   prog_sel <= psel_bit;
   end
endmodule

// File: rtl/dlreq_ctrl.sv
module dlreq_ctrl
   import dlreq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned KEY_ADDR     = 0,
   parameter int unsigned CTRL_ADDR    = 1,
   parameter int unsigned PSEL_ADDR    = 2,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5,
   parameter bit          KEY_READABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cpu_in_ram,
   input  logic              ram_emul_on,
   input  logic              xfer_done,
   output logic              dl_start,
   output logic              dl_busy,
   output logic              prog_sel
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("dlreq_ctrl: DATA_W must be at least 1");
   end
   if (KEY_ADDR == CTRL_ADDR || KEY_ADDR == PSEL_ADDR || CTRL_ADDR == PSEL_ADDR) begin : g_addr_clash
      $error("dlreq_ctrl: register addresses must differ");
   end
   if (KEY_ADDR >= ADDR_SPAN || CTRL_ADDR >= ADDR_SPAN || PSEL_ADDR >= ADDR_SPAN) begin : g_addr_range
      $error("dlreq_ctrl: register address outside ADDR_W");
   end

   dl_sel_e           sel;
   logic              wr_key, wr_ctrl, wr_psel;
   logic [DATA_W-1:0] key_q;
   logic              accept;
   logic [DATA_W-1:0] key_view;

   dlreq_decode #(
      .ADDR_W   (ADDR_W),
      .KEY_ADDR (KEY_ADDR),
      .CTRL_ADDR(CTRL_ADDR),
      .PSEL_ADDR(PSEL_ADDR)
   ) u_decode (
      .bus_addr(bus_addr),
      .bus_we  (bus_we),
      .sel     (sel),
      .wr_key  (wr_key),
      .wr_ctrl (wr_ctrl),
      .wr_psel (wr_psel)
   );

   dlreq_gate #(
      .DATA_W    (DATA_W),
      .UNLOCK_KEY(UNLOCK_KEY)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_key     (wr_key),
      .wdata      (bus_wdata),
      .wr_ctrl    (wr_ctrl),
      .req_bit    (bus_wdata[REQ_BIT]),
      .cpu_in_ram (cpu_in_ram),
      .ram_emul_on(ram_emul_on),
      .busy       (dl_busy),
      .key_q      (key_q),
      .accept     (accept)
   );

   dlreq_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .xfer_done(xfer_done),
      .wr_psel  (wr_psel),
      .psel_bit (bus_wdata[PSEL_BIT]),
      .dl_start (dl_start),
      .dl_busy  (dl_busy),
      .prog_sel (prog_sel)
   );

   if (KEY_READABLE) begin : g_key_rd
      assign key_view = key_q;
   end else begin : g_key_hidden
      assign key_view = '0;
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_KEY:  bus_rdata = key_view;
         SEL_PSEL: bus_rdata[PSEL_BIT] = prog_sel;
         default:  bus_rdata = '0; // request bit never reads as 1
      endcase
   end
endmodule

// File: rtl/dlreq_chk.sv
module dlreq_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned PSEL_ADDR = 2,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cpu_in_ram,
   input logic              ram_emul_on,
   input logic              xfer_done,
   input logic              dl_start,
   input logic              dl_busy,
   input logic [DATA_W-1:0] key_q
);
   logic req_wr;
   assign req_wr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_wdata[0];

   a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      dl_start |=> !dl_start);
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      dl_start |-> dl_busy);
   a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && key_q != UNLOCK_KEY) |=> !dl_start);
   a_r4_not_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && !cpu_in_ram) |=> !dl_start);
   a_r5_emulation: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && ram_emul_on) |=> !dl_start);
   a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && dl_busy) |=> (!dl_busy && !dl_start));
   a_r7_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata == '0));
   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(PSEL_ADDR)) |-> (bus_rdata[DATA_W-1:1] == '0));
endmodule

bind dlreq_ctrl dlreq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CTRL_ADDR (CTRL_ADDR),
   .PSEL_ADDR (PSEL_ADDR),
   .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .cpu_in_ram (cpu_in_ram),
   .ram_emul_on(ram_emul_on),
   .xfer_done  (xfer_done),
   .dl_start   (dl_start),
   .dl_busy    (dl_busy),
   .key_q      (key_q)
);

// File: tb/dlreq_ctrl_bench.sv
`timescale 1ns/1ps
module dlreq_ctrl_bench;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          cpu_in_ram = 1'b0;
   logic          ram_emul_on = 1'b0;
   logic          xfer_done = 1'b0;
   logic          dl_start, dl_busy, prog_sel;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // behavioural reference state
   logic [7:0] m_key = 8'h00;
   bit m_start = 0, m_busy = 0, m_psel = 0;

   always #2 clk = ~clk;

   dlreq_ctrl u_dlreq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_in_ram(cpu_in_ram),
      .ram_emul_on(ram_emul_on), .xfer_done(xfer_done), .dl_start(dl_start),
      .dl_busy(dl_busy), .prog_sel(prog_sel)
   );

   function automatic logic [7:0] m_read(input logic [AW-1:0] a);
      case (a)
         4'd0:    return m_key;
         4'd2:    return {7'b0, m_psel};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string tag);
      chk(tag, "dl_start", int'(dl_start), int'(m_start));
      chk(tag, "dl_busy", int'(dl_busy), int'(m_busy));
      chk(tag, "prog_sel", int'(prog_sel), int'(m_psel));
   endtask

   // one clock: drive at negedge, check read, advance model at the edge, check outputs
   task automatic step(input string tag, input logic [AW-1:0] a, input bit we,
                       input logic [7:0] d, input bit inram, input bit emul, input bit done);
      bit acc;
      bus_addr = a; bus_we = we; bus_wdata = d;
      cpu_in_ram = inram; ram_emul_on = emul; xfer_done = done;
      #1;
      chk(tag, "rdata", int'(bus_rdata), int'(m_read(a)));
      @(posedge clk);
      acc = we && a == 4'd1 && d[0] && m_key == 8'hA5 && inram && !emul && !m_busy;
      m_start = acc;
      m_busy = acc || (m_busy && !done);
      if (done) m_psel = 0;
      else if (we && a == 4'd2) m_psel = d[0];
      if (we && a == 4'd0) m_key = d;
      @(negedge clk);
      chk_outs(tag);
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      step(tag, a, 0, 8'h00, 1, 0, 0);
   endtask

   task automatic idle(input string tag);
      step(tag, 4'd0, 0, 8'h00, 1, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_outs("R10");
      rd("R10", 4'd0); rd("R10", 4'd1); rd("R10", 4'd2);
      step("R10", 4'd0, 1, 8'hA5, 1, 0, 0);
      step("R10", 4'd1, 1, 8'h00, 1, 0, 0);   // bit 0 clear: nothing
      rd("R1", 4'd0);
      step("R3", 4'd0, 1, 8'h5A, 1, 0, 0);
      step("R3", 4'd1, 1, 8'h01, 1, 0, 0);
      idle("R3");
      step("R3", 4'd0, 1, 8'hA4, 1, 0, 0);
      step("R3", 4'd1, 1, 8'hFF, 1, 0, 0);
      idle("R3");
      rd("R1", 4'd0);
      step("R4", 4'd0, 1, 8'hA5, 1, 0, 0);
      step("R4", 4'd1, 1, 8'h01, 0, 0, 0);
      idle("R4");
      step("R5", 4'd1, 1, 8'h01, 1, 1, 0);
      idle("R5");
      step("R5", 4'd1, 1, 8'h01, 0, 1, 0);
      idle("R5");
      // program select with reserved bits set
      step("R8", 4'd2, 1, 8'hFF, 1, 0, 0);
      rd("R8", 4'd2);
      step("R8", 4'd2, 1, 8'hFE, 1, 0, 0);
      rd("R8", 4'd2);
      step("R8", 4'd2, 1, 8'h81, 1, 0, 0);
      // valid request
      step("R2", 4'd1, 1, 8'h01, 1, 0, 0);
      rd("R7", 4'd1);
      rd("R7", 4'd1);
      step("R6", 4'd1, 1, 8'h01, 1, 0, 0);    // while busy: ignored
      idle("R6");
      rd("R9", 4'd2);
      step("R6", 4'd1, 1, 8'h01, 1, 0, 1);    // done and request together
      idle("R6");
      rd("R9", 4'd2);
      // second download, done coinciding with select write
      step("R2", 4'd1, 1, 8'h03, 1, 0, 0);
      idle("R2");
      step("R9", 4'd2, 1, 8'h01, 1, 0, 1);
      rd("R9", 4'd2);
      // done while idle, together with a valid request: accepted
      step("R2", 4'd1, 1, 8'h01, 1, 0, 1);
      step("R6", 4'd0, 0, 8'h00, 1, 0, 1);
      idle("R6");
      // unmapped addresses
      step("R11", 4'd7, 1, 8'hFF, 1, 0, 0);
      rd("R11", 4'd7);
      step("R11", 4'd15, 1, 8'h01, 1, 0, 0);
      rd("R11", 4'd15);
      rd("R1", 4'd0);
      rd("R8", 4'd2);
      // key change after unlock blocks the request
      step("R1", 4'd0, 1, 8'h00, 1, 0, 0);
      rd("R1", 4'd0);
      step("R3", 4'd1, 1, 8'h01, 1, 0, 0);
      idle("R3");
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000 && !finished) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog actual=%0d expected=<5000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule